// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an on-chip request port and an external asynchronous static RAM of 128K sixteen-bit words with a shared data bus. A client presents an address, write data, two byte-lane enables and a read/write flag under a valid/ready handshake. The controller then drives the memory's active-low select, output-enable, write-strobe and the two lane enables, and finishes each access with a one-cycle done flag. For reads, the done flag comes with the captured data.

Each access is stretched over a whole number of clock cycles. These counts come from the memory's nanosecond minimums at the configured clock period, rounded up. A read holds select and output-enable low for the access window and latches the bus on its final cycle. A write drives data for one setup cycle, pulses the write strobe, and then keeps select, lanes and data in place for one more cycle after the strobe rises. The rising strobe is therefore the edge that ends the write. The data-bus tristate is exposed as a separate drive value and drive-enable pair. When a write comes straight after a read, extra bus-released cycles are inserted before the controller drives the bus.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held, and whenever no access is in progress, select, output-enable, write strobe and both lane enables are high, the bus drive-enable is low, and `req_ready` is high.
- R2: A read accepted on a cycle with `req_valid` and `req_ready` high is followed by RD_CYC cycles with select and output-enable low and write strobe high. During these cycles the upper lane enable equals the inverse of `req_be[1]` and the lower lane enable equals the inverse of `req_be[0]`. RD_CYC is the larger of ceil((access time + sample margin)/period) and ceil(read cycle/period), and at least 1; it is 2 by default.
- R3: On the last read cycle the bus is captured into `rsp_rdata`. Bits 7:0 are taken only if `req_be[0]` was set and bits 15:8 only if `req_be[1]` was set; a lane that was not enabled reads as zero.
- R4: A write drives the bus with the request data for the whole access and proceeds in three phases. First comes one cycle with select and the chosen lanes low and the strobe high. Next the strobe is low for WPUL_CYC cycles. Last comes one cycle with the strobe high and everything else unchanged. WPUL_CYC is at least ceil(strobe width/period) and is 1 by default.
- R5: A write changes only the lanes whose enable bit is set; a write with both enable bits clear leaves the word unchanged.
- R6: Output-enable is high in every cycle in which the controller drives the bus, including every cycle of a write.
- R7: A write accepted when the previous access was a read first spends TURN_CYC cycles (default 1) with all strobes high and the bus released, and only then enters its setup cycle. A write after a write, or the first access after reset, gets no such cycles.
- R8: Address, lane enables and drive value stay constant for the whole of an access, and in particular while the write strobe is low.
- R9: `rsp_done` is high for exactly one cycle, in the cycle right after an access's final cycle, and `req_ready` is high only when no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_be | input | 2 | Lane enables, bit 1 = bits 15:8, bit 0 = bits 7:0 |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion flag |
| rsp_rdata | output | 16 | Captured read data, held until the next read |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_out | output | 16 | Value to drive onto the data bus |
| mem_dq_oe | output | 1 | Bus drive enable for the pad tristate |
| mem_dq_in | input | 16 | Value sampled from the data bus |

## Verification
The bench targets the lane masking of reads. It drives junk on the lanes that are not enabled, so a design that forwards the raw bus would return that junk instead of zero. Partial and empty-enable writes are followed by full-word reads of the same address, which exposes a design that writes a lane it should leave alone. Read-to-write pairs are issued back to back. A design that skips the released turnaround cycles, or that leaves output-enable low while driving, shows a drive-enable/output-enable overlap and a cycle-count mismatch against the model. Accesses at address zero and at the top address are also issued, and the done-flag timing is compared on every clock, so a design with an off-by-one read window or a done flag that lasts two cycles is caught.

// File: rtl/sram_ctl_pkg.sv
// Shared types and helpers for the static RAM access sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package sram_ctl_pkg;

    // Phases of one access
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_TURN   = 3'd2,
        ST_WSETUP = 3'd3,
        ST_WPULSE = 3'd4,
        ST_WHOLD  = 3'd5
    } acc_state_t;

    // Memory-side control bundle, all strobes active low
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic ub_n;
        logic lb_n;
        logic dq_oe;
    } mem_ctl_t;

    // Integer ceiling division used for ns-to-cycle conversion
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
// Access phase sequencer: accepts a request when idle and walks it through
// read, turnaround and the three write phases using one down-counter.
// Assumes: cycle counts are already rounded up and are at least 1
// (TURN_CYC may be 0, which removes the turnaround phase).
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC   = 2,
    parameter int WPUL_CYC = 1,
    parameter int TURN_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    output acc_state_t state,
    output logic       ready,
    output logic       rd_last,
    output logic       wr_last
);
    localparam int MAXC      = imax(imax(RD_CYC, WPUL_CYC), imax(TURN_CYC, 1));
    localparam int CNT_W     = $clog2(MAXC + 1);
    localparam int TURN_LOAD = (TURN_CYC > 0) ? TURN_CYC - 1 : 0;

    logic [CNT_W-1:0] cnt_q;
    logic             after_rd_q;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);
    assign ready    = (state == ST_IDLE);
    assign rd_last  = (state == ST_READ) && cnt_zero;
    assign wr_last  = (state == ST_WHOLD);

    // Phase register, remaining-cycle counter and read-history flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt_q      <= '0;
            after_rd_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_write) begin
                            after_rd_q <= 1'b0;
                            if (after_rd_q && (TURN_CYC > 0)) begin
                                state <= ST_TURN;
                                cnt_q <= CNT_W'(TURN_LOAD);
                            end else begin
                                state <= ST_WSETUP;
                            end
                        end else begin
                            after_rd_q <= 1'b1;
                            state      <= ST_READ;
                            cnt_q      <= CNT_W'(RD_CYC - 1);
                        end
                    end
                end
                ST_READ: begin
                    if (cnt_zero) state <= ST_IDLE;
                    else          cnt_q <= cnt_q - CNT_W'(1);
                end
                ST_TURN: begin
                    if (cnt_zero) state <= ST_WSETUP;
                    else          cnt_q <= cnt_q - CNT_W'(1);
                end
                ST_WSETUP: begin
                    state <= ST_WPULSE;
                    cnt_q <= CNT_W'(WPUL_CYC - 1);
                end
                ST_WPULSE: begin
                    if (cnt_zero) state <= ST_WHOLD;
                    else          cnt_q <= cnt_q - CNT_W'(1);
                end
                ST_WHOLD: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // A turnaround phase only ever leads into a write setup
    assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN) |=> (state == ST_TURN) || (state == ST_WSETUP))
        else $error("assert_turn_to_write_R7");

endmodule

// File: rtl/sram_ctl_strobe.sv
// Strobe decoder: maps the current phase and latched lane enables onto the
// memory control pins and the bus drive-enable.
// Assumes: lane enable bit 1 is the upper byte, bit 0 the lower byte.
module sram_ctl_strobe
    import sram_ctl_pkg::*;
(
    input  acc_state_t state,
    input  logic [1:0] be,
    output mem_ctl_t   ctl
);
    // Pure decode of the phase into active-low pins
    always_comb begin
        ctl = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1, dq_oe: 1'b0};
        case (state)
            ST_READ: begin
                ctl.ce_n = 1'b0;
                ctl.oe_n = 1'b0;
                ctl.ub_n = ~be[1];
                ctl.lb_n = ~be[0];
            end
            ST_WSETUP, ST_WHOLD: begin
                ctl.ce_n  = 1'b0;
                ctl.ub_n  = ~be[1];
                ctl.lb_n  = ~be[0];
                ctl.dq_oe = 1'b1;
            end
            ST_WPULSE: begin
                ctl.ce_n  = 1'b0;
                ctl.we_n  = 1'b0;
                ctl.ub_n  = ~be[1];
                ctl.lb_n  = ~be[0];
                ctl.dq_oe = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sram_ctl_rdcap.sv
// Read capture: latches each enabled byte lane of the bus on the final read
// cycle and forces lanes that were not enabled to zero.
// Assumes: capture is a single-cycle pulse aligned with the last read cycle.
module sram_ctl_rdcap #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic [LANES-1:0]        be,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        // Per-lane capture register with masking
        always_ff @(posedge clk) begin
            if (!rst_n)       lane_q <= '0;
            else if (capture) lane_q <= be[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_q;
    end
endmodule

// File: rtl/sram_ctl.sv
// Static RAM access sequencer top: latches a request, converts nanosecond
// minimums into cycle counts, sequences strobes and bus drive, and returns
// a one-cycle done flag with masked read data.
// Assumes: the pad ring builds the bidirectional bus from mem_dq_out,
// mem_dq_oe and mem_dq_in; the clock period is CLK_NS.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W           = 17,
    parameter int CLK_NS           = 10,
    parameter int T_AA_NS          = 10,
    parameter int T_RC_NS          = 10,
    parameter int T_PWE_NS         = 7,
    parameter int T_WC_NS          = 10,
    parameter int T_SD_NS          = 5,
    parameter int SAMPLE_MARGIN_NS = 2,
    parameter int TURN_CYC         = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [15:0]       req_wdata,
    output logic              rsp_done,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);
    localparam int LANE_W   = 8;
    localparam int LANES    = 2;
    localparam int RD_CYC   = imax(1, cdiv(imax(T_AA_NS + SAMPLE_MARGIN_NS, T_RC_NS), CLK_NS));
    localparam int WPUL_CYC = imax(imax(1, cdiv(T_PWE_NS, CLK_NS)),
                                   imax(cdiv(T_WC_NS, CLK_NS) - 2, cdiv(T_SD_NS, CLK_NS) - 1));

    acc_state_t        state;
    mem_ctl_t          ctl;
    logic              rd_last;
    logic              wr_last;
    logic              take;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        be_q;
    logic [15:0]       wdata_q;
    logic              done_q;

    assign take = req_valid && req_ready;

    sram_ctl_seq #(
        .RD_CYC   (RD_CYC),
        .WPUL_CYC (WPUL_CYC),
        .TURN_CYC (TURN_CYC)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .state     (state),
        .ready     (req_ready),
        .rd_last   (rd_last),
        .wr_last   (wr_last)
    );

    sram_ctl_strobe i_strobe (
        .state (state),
        .be    (be_q),
        .ctl   (ctl)
    );

    sram_ctl_rdcap #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) i_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_last),
        .be      (be_q),
        .dq_in   (mem_dq_in),
        .rdata   (rsp_rdata)
    );

    // Hold the accepted request for the whole access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
        end else if (take) begin
            addr_q  <= req_addr;
            be_q    <= req_be;
            wdata_q <= req_wdata;
        end
    end

    // One-cycle completion flag after the final access cycle
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= rd_last || wr_last;
    end

    assign rsp_done   = done_q;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_ce_n   = ctl.ce_n;
    assign mem_oe_n   = ctl.oe_n;
    assign mem_we_n   = ctl.we_n;
    assign mem_ub_n   = ctl.ub_n;
    assign mem_lb_n   = ctl.lb_n;
    assign mem_dq_oe  = ctl.dq_oe;

    // Idle means every strobe released and the bus not driven
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    // Output-enable low only with select low and strobe high
    assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    // Strobe may only fall after a cycle of select low and data driven
    assert_pulse_framed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_dq_oe)));

    // Never drive the bus while the memory may drive it
    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // Drive starts only after a cycle where the memory output was off
    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    // Address, lanes and data frozen while the strobe is low
    assert_stable_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> ($stable(mem_addr) && $stable({mem_ub_n, mem_lb_n}) && $stable(mem_dq_out)));

    // Done never lasts two cycles
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/test_sram_ctl.sv
// Bench: behavioural memory on the pins plus a queue-based expected-pin model
// compared on every falling clock edge.
module test_sram_ctl;
    localparam int CLK_NS = 10;
    localparam int RDC    = (((10 + 2) > 10 ? (10 + 2) : 10) + CLK_NS - 1) / CLK_NS;
    localparam int WPC    = (7 + CLK_NS - 1) / CLK_NS;
    localparam int TRN    = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'h5A5A;

    int checks = 0;
    int fails  = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    sram_ctl i_sram_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---- pin-level memory emulation ----
    logic [15:0] pinmem [int];
    logic        prev_we = 1'b1;

    always @(negedge clk) begin
        logic [15:0] w;
        if (prev_we == 1'b0 && mem_we_n == 1'b1 && mem_ce_n == 1'b0) begin
            w = pinmem.exists(int'(mem_addr)) ? pinmem[int'(mem_addr)] : 16'h0;
            if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
            pinmem[int'(mem_addr)] = w;
        end
        prev_we = mem_we_n;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            w = pinmem.exists(int'(mem_addr)) ? pinmem[int'(mem_addr)] : 16'h0;
            mem_dq_in = {mem_ub_n ? 8'h5A : w[15:8], mem_lb_n ? 8'hA5 : w[7:0]};
        end else begin
            mem_dq_in = 16'h5A5A;
        end
    end

    // ---- expected-pin reference model ----
    typedef struct {
        bit ce, oe, we, ub, lb, dqoe, done, ready, chk_rd;
        logic [16:0] addr;
        logic [15:0] wd;
        logic [15:0] rd;
        string tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] refmem [int];
    bit          last_rd = 1'b0;

    function automatic exp_t idle_e(input bit done, input bit ready, input string tag);
        exp_t e;
        e.ce = 1; e.oe = 1; e.we = 1; e.ub = 1; e.lb = 1; e.dqoe = 0;
        e.done = done; e.ready = ready; e.chk_rd = 0;
        e.addr = '0; e.wd = '0; e.rd = '0; e.tag = tag;
        return e;
    endfunction

    task automatic push_req(input bit w, input logic [16:0] a, input logic [1:0] be,
                            input logic [15:0] d);
        exp_t e;
        logic [15:0] cur;
        cur = refmem.exists(int'(a)) ? refmem[int'(a)] : 16'h0;
        if (!w) begin
            for (int i = 0; i < RDC; i++) begin
                e = idle_e(0, 0, "R2");
                e.ce = 0; e.oe = 0; e.ub = ~be[1]; e.lb = ~be[0]; e.addr = a;
                q.push_back(e);
            end
            e = idle_e(1, 1, "R9");
            e.chk_rd = 1;
            e.rd = {be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00};
            q.push_back(e);
            last_rd = 1;
        end else begin
            if (last_rd)
                for (int i = 0; i < TRN; i++) q.push_back(idle_e(0, 0, "R7"));
            e = idle_e(0, 0, "R4");
            e.ce = 0; e.ub = ~be[1]; e.lb = ~be[0]; e.dqoe = 1; e.addr = a; e.wd = d;
            q.push_back(e);
            for (int i = 0; i < WPC; i++) begin
                e.we = 0;
                q.push_back(e);
            end
            e.we = 1;
            q.push_back(e);
            q.push_back(idle_e(1, 1, "R9"));
            // R5: only enabled lanes change
            if (be[0]) cur[7:0]  = d[7:0];
            if (be[1]) cur[15:8] = d[15:8];
            refmem[int'(a)] = cur;
            last_rd = 0;
        end
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (model_on) begin
            e = (q.size() > 0) ? q.pop_front() : idle_e(0, 1, "R1");
            chk(mem_ce_n == e.ce, e.tag, "ce_n", mem_ce_n, e.ce);
            chk(mem_oe_n == e.oe, e.tag, "oe_n", mem_oe_n, e.oe);
            chk(mem_we_n == e.we, e.tag, "we_n", mem_we_n, e.we);
            chk(mem_ub_n == e.ub, e.tag, "ub_n", mem_ub_n, e.ub);
            chk(mem_lb_n == e.lb, e.tag, "lb_n", mem_lb_n, e.lb);
            chk(mem_dq_oe == e.dqoe, "R6", "dq_oe", mem_dq_oe, e.dqoe);
            chk(!(mem_dq_oe && !mem_oe_n), "R6", "drive while oe low", 1, 0);
            chk(req_ready == e.ready, "R9", "req_ready", req_ready, e.ready);
            chk(rsp_done == e.done, "R9", "rsp_done", rsp_done, e.done);
            if (!e.ce) chk(mem_addr == e.addr, "R8", "mem_addr", mem_addr, e.addr);
            if (e.dqoe) chk(mem_dq_out == e.wd, "R4", "dq_out", mem_dq_out, e.wd);
            if (e.chk_rd) chk(rsp_rdata == e.rd, "R3", "rsp_rdata", rsp_rdata, e.rd);
            if (req_valid && e.ready) push_req(req_write, req_addr, req_be, req_wdata);
        end
    end

    // ---- stimulus ----
    task automatic issue(input bit w, input logic [16:0] a, input logic [1:0] be,
                         input logic [15:0] d);
        req_valid = 1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet pins during reset
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n, "R1", "strobes in reset", 0, 1);
        chk(!mem_dq_oe, "R1", "dq_oe in reset", mem_dq_oe, 0);
        chk(req_ready, "R1", "ready in reset", req_ready, 1);
        @(posedge clk); #1 rst_n = 1;
        model_on = 1;
        @(posedge clk); #1;
        // first write after reset: no turnaround (R7)
        issue(1, 17'h00010, 2'b11, 16'h1234);
        issue(0, 17'h00010, 2'b11, 16'h0);        // R2 full read
        issue(1, 17'h00010, 2'b01, 16'hABCD);     // R7 read->write, R5 low lane only
        issue(0, 17'h00010, 2'b11, 16'h0);        // expect 12CD
        issue(1, 17'h00010, 2'b10, 16'hEF99);     // R5 high lane only
        issue(1, 17'h00010, 2'b00, 16'hFFFF);     // R5 no lanes: unchanged
        issue(0, 17'h00010, 2'b11, 16'h0);        // expect EFCD
        issue(0, 17'h00010, 2'b01, 16'h0);        // R3 upper reads zero
        issue(0, 17'h00010, 2'b10, 16'h0);        // R3 lower reads zero
        issue(0, 17'h00010, 2'b00, 16'h0);        // R3 both zero
        issue(1, 17'h00000, 2'b11, 16'h0F0F);     // boundary address low
        issue(1, 17'h1FFFF, 2'b11, 16'hF00D);     // boundary address high
        issue(0, 17'h00000, 2'b11, 16'h0);
        issue(0, 17'h1FFFF, 2'b11, 16'h0);
        for (int n = 0; n < 400; n++)
            issue(1'($urandom_range(0, 1)), 17'($urandom_range(0, 7)) | 17'h1FFF8,
                  2'($urandom_range(0, 3)), 16'($urandom));
        repeat (10) @(posedge clk);
        chk(q.size() == 0, "R9", "model queue drained", q.size(), 0);
        finish_run();
    end
endmodule